// File: doc/BRIEF.md
# Memory Controller Chip-Select Configuration Registers

This block is the software-visible register file of an external memory controller, together with the address decoder that drives it. It holds a general control word, a captured copy of the power-on strap word, and a shared base-address mask. For each chip select it also holds a configuration word and a timing word. From these it produces, every cycle and without added latency, a mask, a compare value and a valid flag for each chip select. A priority decoder then picks the single chip select that owns an incoming system address.

The register port is word wide. A write is committed on the rising clock edge. A read returns data combinationally for the offset that is presented. Reset is synchronous and active low. While reset is held, the strap word is captured, and chip select 0 comes up already enabled, with a memory type, bus width and timing taken from the straps. Software can therefore reach boot memory before it programs anything.

Top module: `memctl_cfg_regs`

## Requirements
- R1: The byte offsets are fixed: control word at 0x00, strap word at 0x04, base mask at 0x08. Chip select n has its configuration word at 0x10+8n and its timing word at 0x14+8n. A value written to any writable offset reads back from that offset on the next cycle.
- R2: The strap word at 0x04 reads as the value of `strap_i` captured during reset. A write to 0x04 leaves it unchanged.
- R3: The base mask stores only its low 8 bits. Bits 31:8 always read as 0.
- R4: Every chip select's mask output equals the base mask shifted left by 22. All of them change in the cycle after a write to 0x08.
- R5: Chip select n's compare output equals configuration bits [23:16] (the select field) shifted left by 22.
- R6: Chip select n's valid output equals bit 0 (enable) of its configuration word.
- R7: After reset the control word, base mask and all per-chip-select words are 0, with one exception. Chip select 0's configuration word has enable bit 0 set to 1, type field [3:1] = {0, strap[3:2]} and width field [5:4] = strap[1:0].
- R8: After reset, chip select 0's timing word depends on the type code. Code 0 (SDRAM) gives 0x0F120435, code 1 (SSRAM) gives 0x000000FF, code 2 (asynchronous) gives 0x03FFFFFF and code 3 (synchronous) gives 0x0003FFFF.
- R9: An offset that is not listed in R1 reads as 0, and a write to it changes no register and no output. This covers 0x0C, offsets past the last timing word, and offsets that are not word aligned.
- R10: Chip select n matches when it is valid and (`sys_addr_i` AND its mask) equals its compare value.
- R11: When several chip selects match, only the lowest-numbered one is flagged in `cs_hit_o`. `cs_any_o` is high exactly when some chip select matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_i | input | 32 | Power-on strap word, captured while in reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| sys_addr_i | input | 32 | System address to decode |
| cs_mask_o | output | 256 | Per chip select address mask, chip select n in bits [32n+31:32n] |
| cs_cmp_o | output | 256 | Per chip select compare value, same packing |
| cs_valid_o | output | 8 | Per chip select valid flag |
| cs_hit_o | output | 8 | Winning chip select, at most one bit set |
| cs_any_o | output | 1 | Some chip select matched |

## Verification
The mask, compare and valid outputs are combinational views of the stored words. A register that was written wrongly, for instance at the wrong index, with unmasked bits, or after a stray write, therefore shows on those outputs in the very next cycle. The bench compares them against its model on every clock. The corrupted word also shows through a read sweep of the whole offset space, including offsets outside the map. Decoder faults (wrong priority, disabled chip selects still matching) show at once on `cs_hit_o` for addresses chosen to match more than one chip select. Reset faults are caught by reading chip select 0 back after two resets with different strap types.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

   // configuration word field layout
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_TYPE_LSB = 1;
   localparam int CFG_TYPE_W   = 3;
   localparam int CFG_BW_LSB   = 4;
   localparam int CFG_BW_W     = 2;
   localparam int CFG_SEL_LSB  = 16;
   localparam int CFG_SEL_W    = 8;

   // address decode alignment
   localparam int DECODE_SHIFT = 22;

   // register byte offsets
   localparam int OFS_CTL     = 0;
   localparam int OFS_STRAP   = 4;
   localparam int OFS_BMASK   = 8;
   localparam int OFS_CS_BASE = 16;
   localparam int CS_STRIDE   = 8;

   typedef enum logic [CFG_TYPE_W-1:0] {
      MT_SDRAM = 3'd0,
      MT_SSRAM = 3'd1,
      MT_ASYNC = 3'd2,
      MT_SYNC  = 3'd3
   } mem_type_e;

   localparam logic [31:0] TIM_DEF_SDRAM = 32'h0F12_0435;
   localparam logic [31:0] TIM_DEF_SSRAM = 32'h0000_00FF;
   localparam logic [31:0] TIM_DEF_ASYNC = 32'h03FF_FFFF;
   localparam logic [31:0] TIM_DEF_SYNC  = 32'h0003_FFFF;

   function automatic logic [31:0] tim_default(input logic [CFG_TYPE_W-1:0] t);
      logic [31:0] v;
      case (t)
         MT_SDRAM: v = TIM_DEF_SDRAM;
         MT_SSRAM: v = TIM_DEF_SSRAM;
         MT_ASYNC: v = TIM_DEF_ASYNC;
         MT_SYNC:  v = TIM_DEF_SYNC;
         default:  v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/memctl_cfg_bank.sv
module memctl_cfg_bank
   import memctl_cfg_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int DW     = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [3:0]                 strap_low,
   input  logic [NUM_CS-1:0]          wr_cfg,
   input  logic [NUM_CS-1:0]          wr_tim,
   input  logic [DW-1:0]              wdata,
   input  logic [DW-1:0]              bmask_q,
   output logic [NUM_CS-1:0][DW-1:0]  cfg_q,
   output logic [NUM_CS-1:0][DW-1:0]  tim_q,
   output logic [NUM_CS-1:0][DW-1:0]  cs_mask,
   output logic [NUM_CS-1:0][DW-1:0]  cs_cmp,
   output logic [NUM_CS-1:0]          cs_valid
);

   // boot values of chip select 0, derived from straps
   logic [CFG_TYPE_W-1:0] boot_type;
   logic [DW-1:0]         boot_cfg;
   logic [DW-1:0]         boot_tim;

   always_comb begin
      boot_type = {1'b0, strap_low[3:2]};
      boot_cfg  = '0;
      boot_cfg[CFG_EN_BIT]                 = 1'b1;
      boot_cfg[CFG_TYPE_LSB +: CFG_TYPE_W] = boot_type;
      boot_cfg[CFG_BW_LSB   +: CFG_BW_W]   = strap_low[1:0];
      boot_tim  = DW'(tim_default(boot_type));
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      if (g == 0) begin : g_boot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cfg_q[g] <= boot_cfg;
               tim_q[g] <= boot_tim;
            end else begin
               if (wr_cfg[g]) cfg_q[g] <= wdata;
               if (wr_tim[g]) tim_q[g] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cfg_q[g] <= '0;
               tim_q[g] <= '0;
            end else begin
               if (wr_cfg[g]) cfg_q[g] <= wdata;
               if (wr_tim[g]) tim_q[g] <= wdata;
            end
         end
      end

      assign cs_mask[g]  = bmask_q << DECODE_SHIFT;
      assign cs_cmp[g]   = DW'(cfg_q[g][CFG_SEL_LSB +: CFG_SEL_W]) << DECODE_SHIFT;
      assign cs_valid[g] = cfg_q[g][CFG_EN_BIT];
   end

endmodule

// File: rtl/memctl_cfg_decode.sv
module memctl_cfg_decode #(
   parameter int NUM_CS = 8,
   parameter int DW     = 32
) (
   input  logic [DW-1:0]              sys_addr,
   input  logic [NUM_CS-1:0][DW-1:0]  cs_mask,
   input  logic [NUM_CS-1:0][DW-1:0]  cs_cmp,
   input  logic [NUM_CS-1:0]          cs_valid,
   output logic [NUM_CS-1:0]          cs_hit,
   output logic                       cs_any
);

   logic [NUM_CS-1:0] raw_match;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
      assign raw_match[g] = cs_valid[g] && ((sys_addr & cs_mask[g]) == cs_cmp[g]);
   end

   // lowest index wins
   always_comb begin
      logic taken;
      taken  = 1'b0;
      cs_hit = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (raw_match[i] && !taken) begin
            cs_hit[i] = 1'b1;
            taken     = 1'b1;
         end
      end
   end

   assign cs_any = |raw_match;

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
   import memctl_cfg_pkg::*;
#(
   parameter int NUM_CS     = 8,
   parameter int DW         = 32,
   parameter int ADDR_W     = 8,
   parameter int BMASK_BITS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DW-1:0]          strap_i,
   input  logic                   reg_we_i,
   input  logic [ADDR_W-1:0]      reg_addr_i,
   input  logic [DW-1:0]          reg_wdata_i,
   output logic [DW-1:0]          reg_rdata_o,
   input  logic [DW-1:0]          sys_addr_i,
   output logic [NUM_CS*DW-1:0]   cs_mask_o,
   output logic [NUM_CS*DW-1:0]   cs_cmp_o,
   output logic [NUM_CS-1:0]      cs_valid_o,
   output logic [NUM_CS-1:0]      cs_hit_o,
   output logic                   cs_any_o
);

   localparam int CSI_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
   localparam int LAST_OFS = OFS_CS_BASE + CS_STRIDE * NUM_CS - 4;
   localparam int NEED_AW  = $clog2(LAST_OFS + 4);
   localparam logic [DW-1:0] BMASK_VALID = {{(DW-BMASK_BITS){1'b0}}, {BMASK_BITS{1'b1}}};

   // elaboration-time parameter checks
   if (NUM_CS < 2 || (NUM_CS & (NUM_CS - 1)) != 0) begin : g_chk_cs
      $error("NUM_CS must be a power of two, at least 2");
   end
   if (ADDR_W < NEED_AW) begin : g_chk_aw
      $error("ADDR_W too narrow for the register map");
   end
   if (DW < DECODE_SHIFT + BMASK_BITS || DW < DECODE_SHIFT + CFG_SEL_W || DW < 32) begin : g_chk_dw
      $error("DW too narrow for the decode fields");
   end

   logic [DW-1:0]              ctl_q, poc_q, bmask_q;
   logic [NUM_CS-1:0][DW-1:0]  cfg_q, tim_q, cs_mask, cs_cmp;
   logic [NUM_CS-1:0]          wr_cfg, wr_tim;
   logic [ADDR_W-1:0]          rel;
   logic [CSI_W-1:0]           cs_idx;
   logic                       in_cs, hit_ctl, hit_poc, hit_bm;

   // offset decode
   always_comb begin
      hit_ctl = (reg_addr_i == ADDR_W'(OFS_CTL));
      hit_poc = (reg_addr_i == ADDR_W'(OFS_STRAP));
      hit_bm  = (reg_addr_i == ADDR_W'(OFS_BMASK));
      in_cs   = (reg_addr_i >= ADDR_W'(OFS_CS_BASE)) &&
                (reg_addr_i <= ADDR_W'(LAST_OFS)) &&
                (reg_addr_i[1:0] == 2'b00);
      rel     = reg_addr_i - ADDR_W'(OFS_CS_BASE);
      cs_idx  = rel[CSI_W+2:3];
      wr_cfg  = '0;
      wr_tim  = '0;
      if (reg_we_i && in_cs) begin
         if (rel[2]) wr_tim[cs_idx] = 1'b1;
         else        wr_cfg[cs_idx] = 1'b1;
      end
   end

   // global registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         bmask_q <= '0;
         poc_q   <= strap_i;
      end else if (reg_we_i) begin
         if (hit_ctl) ctl_q   <= reg_wdata_i;
         if (hit_bm)  bmask_q <= reg_wdata_i & BMASK_VALID;
      end
   end

   memctl_cfg_bank #(.NUM_CS(NUM_CS), .DW(DW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_low(strap_i[3:0]),
      .wr_cfg   (wr_cfg),
      .wr_tim   (wr_tim),
      .wdata    (reg_wdata_i),
      .bmask_q  (bmask_q),
      .cfg_q    (cfg_q),
      .tim_q    (tim_q),
      .cs_mask  (cs_mask),
      .cs_cmp   (cs_cmp),
      .cs_valid (cs_valid_o)
   );

   memctl_cfg_decode #(.NUM_CS(NUM_CS), .DW(DW)) u_dec (
      .sys_addr (sys_addr_i),
      .cs_mask  (cs_mask),
      .cs_cmp   (cs_cmp),
      .cs_valid (cs_valid_o),
      .cs_hit   (cs_hit_o),
      .cs_any   (cs_any_o)
   );

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      if (hit_ctl)      reg_rdata_o = ctl_q;
      else if (hit_poc) reg_rdata_o = poc_q;
      else if (hit_bm)  reg_rdata_o = bmask_q;
      else if (in_cs)   reg_rdata_o = rel[2] ? tim_q[cs_idx] : cfg_q[cs_idx];
   end

   assign cs_mask_o = cs_mask;
   assign cs_cmp_o  = cs_cmp;

endmodule

// File: rtl/memctl_cfg_chk.sv
module memctl_cfg_chk #(
   parameter int NUM_CS     = 8,
   parameter int DW         = 32,
   parameter int ADDR_W     = 8,
   parameter int BMASK_BITS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  we,
   input logic [ADDR_W-1:0]     addr,
   input logic [DW-1:0]         wdata,
   input logic [DW-1:0]         poc,
   input logic [DW-1:0]         ctl,
   input logic [NUM_CS*DW-1:0]  mask,
   input logic [NUM_CS*DW-1:0]  cmp,
   input logic [NUM_CS-1:0]     valid,
   input logic [NUM_CS-1:0]     hit,
   input logic                  any_hit
);

   localparam int LAST = 16 + 8 * NUM_CS - 4;
   localparam logic [DW-1:0] KEEP = {{(DW-BMASK_BITS){1'b0}}, {BMASK_BITS{1'b1}}};

   logic mapped;
   assign mapped = (addr == ADDR_W'(0)) || (addr == ADDR_W'(4)) || (addr == ADDR_W'(8)) ||
                   ((addr >= ADDR_W'(16)) && (addr <= ADDR_W'(LAST)) && (addr[1:0] == 2'b00));

   a_r2_strap_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(4)) |=> $stable(poc));

   a_r4_mask_all_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(8)) |=> (mask == {NUM_CS{($past(wdata) & KEEP) << 22}}));

   a_r9_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !mapped) |=> ($stable(ctl) && $stable(mask) && $stable(cmp) && $stable(valid)));

   a_r7_only_cs0_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (valid == NUM_CS'(1)));

   a_r11_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit) && (any_hit == (hit != '0)));

   a_r10_hit_requires_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (hit & ~valid) == '0);

endmodule

bind memctl_cfg_regs memctl_cfg_chk #(
   .NUM_CS(NUM_CS), .DW(DW), .ADDR_W(ADDR_W), .BMASK_BITS(BMASK_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
   .poc(poc_q), .ctl(ctl_q), .mask(cs_mask_o), .cmp(cs_cmp_o), .valid(cs_valid_o),
   .hit(cs_hit_o), .any_hit(cs_any_o)
);

// File: tb/tb_memctl_cfg_regs.sv
`timescale 1ns/1ps
module tb_memctl_cfg_regs;

   localparam int NCS = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [31:0]       strap_i = '0;
   logic              reg_we_i = 1'b0;
   logic [7:0]        reg_addr_i = '0;
   logic [31:0]       reg_wdata_i = '0;
   logic [31:0]       reg_rdata_o;
   logic [31:0]       sys_addr_i = '0;
   logic [NCS*32-1:0] cs_mask_o, cs_cmp_o;
   logic [NCS-1:0]    cs_valid_o, cs_hit_o;
   logic              cs_any_o;

   int checks = 0;
   int fails  = 0;
   bit run    = 1'b0;

   always #2.5 clk = ~clk;

   memctl_cfg_regs dut (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .reg_we_i(reg_we_i),
      .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .sys_addr_i(sys_addr_i), .cs_mask_o(cs_mask_o), .cs_cmp_o(cs_cmp_o),
      .cs_valid_o(cs_valid_o), .cs_hit_o(cs_hit_o), .cs_any_o(cs_any_o)
   );

   // behavioural reference model
   logic [31:0] m_ctl, m_poc, m_bm;
   logic [31:0] m_cfg [NCS];
   logic [31:0] m_tim [NCS];

   function automatic logic [31:0] def_timing(int t);
      case (t)
         0: return 32'h0F12_0435;
         1: return 32'h0000_00FF;
         2: return 32'h03FF_FFFF;
         default: return 32'h0003_FFFF;
      endcase
   endfunction

   function automatic void m_reset(logic [31:0] s);
      m_ctl = 0; m_bm = 0; m_poc = s;
      for (int n = 0; n < NCS; n++) begin m_cfg[n] = 0; m_tim[n] = 0; end
      m_cfg[0] = 32'd1 + (32'(s[3:2]) * 2) + (32'(s[1:0]) * 16);
      m_tim[0] = def_timing(int'(s[3:2]));
   endfunction

   function automatic void m_write(int a, logic [31:0] d);
      if (a == 0) m_ctl = d;
      else if (a == 8) m_bm = d & 32'hFF;
      else if (a >= 16 && a <= 16 + 8*NCS - 4 && a % 4 == 0) begin
         if ((a - 16) % 8 == 4) m_tim[(a - 16) / 8] = d;
         else                   m_cfg[(a - 16) / 8] = d;
      end
   endfunction

   function automatic logic [31:0] m_read(int a);
      if (a == 0) return m_ctl;
      if (a == 4) return m_poc;
      if (a == 8) return m_bm;
      if (a >= 16 && a <= 16 + 8*NCS - 4 && a % 4 == 0)
         return ((a - 16) % 8 == 4) ? m_tim[(a - 16) / 8] : m_cfg[(a - 16) / 8];
      return 0;
   endfunction

   function automatic int m_winner(logic [31:0] sa);
      for (int n = 0; n < NCS; n++)
         if (m_cfg[n][0] && ((sa & (m_bm << 22)) == ({24'd0, m_cfg[n][23:16]} << 22))) return n;
      return -1;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // per-clock comparison of the decode outputs against the model
   always @(negedge clk) begin
      if (run) begin
         int w;
         for (int n = 0; n < NCS; n++) begin
            chk("R4", $sformatf("mask cs%0d", n), cs_mask_o[n*32 +: 32], m_bm << 22);
            chk("R5", $sformatf("cmp cs%0d", n), cs_cmp_o[n*32 +: 32], {24'd0, m_cfg[n][23:16]} << 22);
            chk("R6", $sformatf("valid cs%0d", n), 32'(cs_valid_o[n]), 32'(m_cfg[n][0]));
         end
         w = m_winner(sys_addr_i);
         chk("R11", "hit vector", 32'(cs_hit_o), (w < 0) ? 32'd0 : (32'd1 << w));
         chk("R10", "any match", 32'(cs_any_o), 32'(w >= 0));
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_we_i = 1'b1; reg_addr_i = 8'(a); reg_wdata_i = d;
      @(posedge clk);
      m_write(a, d);
      @(negedge clk);
      reg_we_i = 1'b0;
   endtask

   task automatic rd_chk(string req, int a);
      reg_addr_i = 8'(a);
      #0.1;
      chk(req, $sformatf("read @%0h", a), reg_rdata_o, m_read(a));
   endtask

   task automatic sweep(string req);
      for (int a = 0; a < 256; a += 4) rd_chk(req, a);
   endtask

   task automatic do_reset(logic [31:0] s);
      run = 1'b0;
      @(negedge clk);
      rst_n = 1'b0; strap_i = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_reset(s);
      strap_i = 32'hFFFF_FFFF;  // straps only matter during reset
      run = 1'b1;
   endtask

   task automatic hit_chk(string req, logic [31:0] sa, logic [7:0] exp_hit);
      @(negedge clk);
      sys_addr_i = sa;
      #0.1;
      chk(req, $sformatf("hit for %h", sa), 32'(cs_hit_o), 32'(exp_hit));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // reset with SSRAM straps (type 1, width 2)
      do_reset(32'h1234_5606);
      rd_chk("R7", 16);
      chk("R7", "cs0 config", m_read(16), 32'h0000_0023);
      rd_chk("R8", 20);
      chk("R8", "cs0 timing ssram", m_read(20), 32'h0000_00FF);
      rd_chk("R2", 4);
      sweep("R7");

      // map and read back
      wr(0, 32'hDEAD_BEEF);
      wr(16 + 8*3, 32'h0055_0000);
      wr(16 + 8*7 + 4, 32'hCAFE_F00D);
      wr(16 + 8*2 + 4, 32'h1357_9BDF);
      rd_chk("R1", 0);
      rd_chk("R1", 16 + 8*7 + 4);
      sweep("R1");

      // base mask truncation
      wr(8, 32'hFFFF_FFFF);
      rd_chk("R3", 8);
      chk("R3", "mask stored", m_read(8), 32'h0000_00FF);
      wr(8, 32'hABCD_EF5A);
      rd_chk("R3", 8);

      // strap word read only
      wr(4, 32'h0BAD_0BAD);
      rd_chk("R2", 4);
      chk("R2", "strap word", m_read(4), 32'h1234_5606);

      // unmapped offsets
      wr(12, 32'h1111_1111);
      wr(17, 32'h2222_2222);
      wr(16 + 8*NCS, 32'h3333_3333);
      wr(252, 32'h4444_4444);
      rd_chk("R9", 12);
      rd_chk("R9", 16 + 8*NCS);
      rd_chk("R9", 17);
      sweep("R9");

      // decode setup: mask bits 29:26
      wr(8, 32'h0000_00F0);
      wr(16, 32'h0000_0001);
      wr(16 + 8*1, 32'h0010_0001);
      wr(16 + 8*2, 32'h0010_0001);
      wr(16 + 8*3, 32'h0020_0000);
      wr(16 + 8*5, 32'h0020_0001);
      hit_chk("R11", 32'h0400_0000, 8'b0000_0010);
      hit_chk("R10", 32'h0800_0000, 8'b0010_0000);
      hit_chk("R10", 32'h0000_1234, 8'b0000_0001);
      hit_chk("R10", 32'hF000_0000, 8'b0000_0000);
      wr(16 + 8*1, 32'h0010_0000);
      hit_chk("R11", 32'h0400_0000, 8'b0000_0100);
      wr(16, 32'h0000_0000);
      hit_chk("R6", 32'h0000_1234, 8'b0000_0000);

      // reset with asynchronous straps (type 2, width 3)
      do_reset(32'h0000_000B);
      rd_chk("R7", 16);
      chk("R7", "cs0 config", m_read(16), 32'h0000_0035);
      rd_chk("R8", 20);
      chk("R8", "cs0 timing async", m_read(20), 32'h03FF_FFFF);
      sweep("R7");

      // SDRAM and synchronous defaults
      do_reset(32'h0000_0000);
      rd_chk("R8", 20);
      do_reset(32'h0000_000C);
      rd_chk("R8", 20);
      chk("R8", "cs0 timing sync", m_read(20), 32'h0003_FFFF);

      repeat (2) @(negedge clk);
      run = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule